// File: doc/BRIEF.md
# DMA Request and Bus Handshake Controller

This block is the front end of a four-channel DMA engine. Peripherals raise per-channel request lines. The block filters them through a controller-wide disable flag and a per-channel mask. If any request survives the filter, it asks the host for the bus with a hold request. When the host grants the bus, the block chooses one channel by fixed priority and returns an acknowledge to that channel. It also raises a bus-owned flag for the downstream transfer logic. Address generation, data movement and transfer counting sit in other blocks.

The host programs the block through a small write port. Writes are taken whenever the bus grant input is low, including while a hold request is pending. Writes are dropped while the grant is high. Software can mask a channel, or disable the whole controller, before it rewrites that channel's settings. The block comes out of reset disabled with every channel masked, so no output goes active before programming.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel is eligible when its request line is high, its mask bit is 0 and the controller is enabled. Only eligible channels affect any output.
- R2: From idle, `bus_hold_req` rises on the clock edge that first samples an eligible request. It never rises without one.
- R3: Write select 0 is the command register. Its data bit 2 set to 1 disables the controller and set to 0 enables it. While the controller is disabled, `bus_hold_req` stays low, and a pending hold request drops on the next edge.
- R4: A masked channel's request never raises `bus_hold_req` and never receives an acknowledge.
- R5: A write with `cfg_wr_en` high is applied at the clock edge if `bus_hold_gnt` is low at that edge, even while `bus_hold_req` is high.
- R6: A write presented while `bus_hold_gnt` is high is ignored and leaves every setting unchanged.
- R7: When a hold request is pending and `bus_hold_gnt` is sampled high, the next edge acknowledges the lowest-numbered eligible channel. Channel 0 has the highest priority and channel 3 the lowest.
- R8: At most one bit of `chan_ack` is high. A bit can be high only if `bus_hold_gnt` was high at the previous edge. `bus_owned` is high exactly while some acknowledge is high.
- R9: When the served channel's request is sampled low, its acknowledge and `bus_owned` clear on that edge. `bus_hold_req` clears on the same edge unless another channel is eligible. If another channel is eligible, `bus_hold_req` stays high and arbitration runs again on the following edge.
- R10: After reset, `bus_hold_req`, `chan_ack` and `bus_owned` are low, every channel is masked and the controller is disabled.
- R11: Write select 1 loads all mask bits from data bits 3:0. Write select 2 changes one mask bit: data bits 1:0 give the channel and data bit 2 gives the new mask value. Write select 3 has no effect.
- R12: If `bus_hold_gnt` is sampled low during service, the acknowledge and `bus_owned` clear on that edge. The hold request stays high if any channel is still eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Host register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 command, 1 all masks, 2 one mask, 3 none |
| cfg_wr_data | input | 8 | Write data |
| chan_req | input | 4 | Per-channel peripheral request |
| bus_hold_gnt | input | 1 | Host grants the bus |
| bus_hold_req | output | 1 | Request for the bus to the host |
| chan_ack | output | 4 | One-hot per-channel acknowledge |
| bus_owned | output | 1 | Bus held by the block, for downstream logic |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of fault:
- A write that lands while a hold request is pending must still apply. A design that locks out on the hold request instead of the grant would keep the request high after a disable write.
- A mask write issued during a grant must be ignored. Otherwise a channel would vanish from the next arbitration.
- When the served request drops while another channel waits, the hold request must stay high and the next acknowledge must follow one edge later. A wrong design either drops the hold request or acknowledges two channels.
- Withdrawing the grant mid-transfer must clear the acknowledge. Inverted priority or a lost single-bit mask write would show up as the wrong channel being acknowledged under random traffic.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_SERVE = 2'd2
  } arb_state_e;

  localparam logic [1:0] WSEL_CMD      = 2'd0;
  localparam logic [1:0] WSEL_MASK_ALL = 2'd1;
  localparam logic [1:0] WSEL_MASK_ONE = 2'd2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_req_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 8,
  parameter int DIS_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold_gnt,
  output logic              ctrl_off,
  output logic [NUM_CH-1:0] ch_mask
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              off_q;
  logic [NUM_CH-1:0] mask_q;
  logic              wr_ok;
  logic              unused_wr_bits;

  // host writes are locked out only while the bus is granted
  assign wr_ok          = wr_en & ~hold_gnt;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= 1'b1;
    end else if (wr_ok && wr_sel == WSEL_CMD) begin
      off_q <= wr_data[DIS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_sel == WSEL_MASK_ALL) begin
          mask_q[i] <= wr_data[i];
        end else if (wr_sel == WSEL_MASK_ONE &&
                     wr_data[CH_W-1:0] == CH_W'(i)) begin
          mask_q[i] <= wr_data[CH_W];
        end
      end
    end
  end

  assign ctrl_off = off_q;
  assign ch_mask  = mask_q;

  // R6: settings frozen across any edge where the grant is high
  p_regs_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_gnt && !rst) |=> ($stable(mask_q) && $stable(off_q)));

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] grant
);

  logic [NUM_CH:0] higher;

  assign higher[0] = 1'b0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prio
    assign higher[i+1] = higher[i] | req[i];
    assign grant[i]    = req[i] & ~higher[i];
  end

  // R7: a single winner whenever anything requests
  always_comb begin
    if (!$isunknown(req)) begin
      a_grant_onehot_r7: assert ($onehot0(grant) && ((req == '0) == (grant == '0)));
    end
  end

endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
  import dma_req_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_gnt,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic [NUM_CH-1:0] eligible,
  input  logic [NUM_CH-1:0] grant,
  output logic              hold_req,
  output logic [NUM_CH-1:0] chan_ack,
  output logic              owned
);

  arb_state_e        st_q;
  logic              hreq_q;
  logic [NUM_CH-1:0] ack_q;
  logic              own_q;
  logic              any_elig;
  logic              served_live;

  assign any_elig    = |eligible;
  assign served_live = |(chan_req & ack_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hreq_q <= 1'b0;
      ack_q  <= '0;
      own_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (any_elig) begin
            hreq_q <= 1'b1;
            st_q   <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (!any_elig) begin
            hreq_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (hold_gnt) begin
            ack_q <= grant;
            own_q <= 1'b1;
            st_q  <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          if (!hold_gnt || !served_live) begin
            ack_q <= '0;
            own_q <= 1'b0;
            if (any_elig) begin
              st_q <= ST_PEND;
            end else begin
              hreq_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          hreq_q <= 1'b0;
          ack_q  <= '0;
          own_q  <= 1'b0;
        end
      endcase
    end
  end

  assign hold_req = hreq_q;
  assign chan_ack = ack_q;
  assign owned    = own_q;

  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_q));

  p_ack_after_grant_r8: assert property (@(posedge clk) disable iff (rst)
    (|ack_q) |-> $past(hold_gnt));

  p_owned_tracks_ack_r8: assert property (@(posedge clk) disable iff (rst)
    own_q == (|ack_q));

  p_hold_needs_elig_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hreq_q) |-> $past(any_elig));

  p_ack_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PEND && hold_gnt && any_elig) |=> (ack_q == $past(grant)));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVE && !served_live) |=> (ack_q == '0 && !own_q));

  p_grant_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SERVE && !hold_gnt) |=> (ack_q == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 8,
  parameter int DIS_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [NUM_CH-1:0] chan_req,
  input  logic              bus_hold_gnt,
  output logic              bus_hold_req,
  output logic [NUM_CH-1:0] chan_ack,
  output logic              bus_owned
);

  logic              ctrl_off;
  logic [NUM_CH-1:0] ch_mask;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] grant;

  dma_cfg_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .DIS_BIT(DIS_BIT)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .hold_gnt(bus_hold_gnt),
    .ctrl_off(ctrl_off),
    .ch_mask (ch_mask)
  );

  // R1: request filtered by mask and global enable
  assign eligible = chan_req & ~ch_mask & {NUM_CH{~ctrl_off}};

  dma_prio_pick #(
    .NUM_CH(NUM_CH)
  ) u_prio (
    .req  (eligible),
    .grant(grant)
  );

  dma_hold_fsm #(
    .NUM_CH(NUM_CH)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .hold_gnt(bus_hold_gnt),
    .chan_req(chan_req),
    .eligible(eligible),
    .grant   (grant),
    .hold_req(bus_hold_req),
    .chan_ack(chan_ack),
    .owned   (bus_owned)
  );

  // R3, R4: nothing is requested when the controller is off or all channels masked
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_off && $past(ctrl_off) && !$past(bus_hold_req)) |-> !bus_hold_req);

  p_masked_no_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (chan_ack & $past(ch_mask)) == '0 || $past(chan_ack) != '0);

endmodule

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = 2'd0;
  logic [7:0] cfg_wr_data = 8'd0;
  logic [3:0] chan_req = 4'd0;
  logic       bus_hold_gnt = 1'b0;
  logic       bus_hold_req;
  logic [3:0] chan_ack;
  logic       bus_owned;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .chan_req(chan_req), .bus_hold_gnt(bus_hold_gnt),
    .bus_hold_req(bus_hold_req), .chan_ack(chan_ack), .bus_owned(bus_owned)
  );

  // ---------------- reference model built from the requirements -------------
  logic       m_off;
  logic [3:0] m_mask;
  int         m_st;
  logic       m_hreq;
  logic [3:0] m_ack;

  function automatic logic [3:0] pick_first(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (r[i]) return 4'b0001 << i;
    return 4'b0000;
  endfunction

  function automatic logic [3:0] elig_of(input logic off, input logic [3:0] msk,
                                         input logic [3:0] rq);
    return off ? 4'b0000 : (rq & ~msk);
  endfunction

  always @(posedge clk) begin
    logic [3:0] e;
    if (rst) begin
      m_off <= 1'b1; m_mask <= 4'hF; m_st <= 0; m_hreq <= 1'b0; m_ack <= 4'h0;
    end else begin
      e = elig_of(m_off, m_mask, chan_req);
      if (cfg_wr_en && !bus_hold_gnt) begin
        case (cfg_wr_sel)
          2'd0: m_off <= cfg_wr_data[2];
          2'd1: m_mask <= cfg_wr_data[3:0];
          2'd2: m_mask[cfg_wr_data[1:0]] <= cfg_wr_data[2];
          default: ;
        endcase
      end
      case (m_st)
        0: if (e != 0) begin m_hreq <= 1'b1; m_st <= 1; end
        1: if (e == 0) begin m_hreq <= 1'b0; m_st <= 0; end
           else if (bus_hold_gnt) begin m_ack <= pick_first(e); m_st <= 2; end
        default: if (!bus_hold_gnt || (chan_req & m_ack) == 0) begin
          m_ack <= 4'h0;
          if (e != 0) m_st <= 1;
          else begin m_hreq <= 1'b0; m_st <= 0; end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R1, R2, R8)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1/R2 bus_hold_req vs model", 32'(bus_hold_req), 32'(m_hreq));
      chk("R1/R8 chan_ack vs model", 32'(chan_ack), 32'(m_ack));
      chk("R8 bus_owned vs model", 32'(bus_owned), 32'(|m_ack));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R10: reset state
    chk("R10 hold after reset", 32'(bus_hold_req), 0);
    chk("R10 ack after reset", 32'(chan_ack), 0);
    chk("R10 owned after reset", 32'(bus_owned), 0);
    chan_req = 4'b0001;
    cyc(3);
    chk("R10 reset masks/disable block request", 32'(bus_hold_req), 0);

    wr(2'd0, 8'h00);              // enable controller
    cyc(3);
    chk("R4 masked channel ignored", 32'(bus_hold_req), 0);

    wr(2'd2, 8'h00);              // R11: unmask channel 0 alone
    cyc(1);
    chk("R11/R2 single unmask raises hold", 32'(bus_hold_req), 1);

    wr(2'd0, 8'h04);              // R5: disable while hold pending
    cyc(1);
    chk("R5/R3 disable write while pending", 32'(bus_hold_req), 0);
    wr(2'd0, 8'h00);
    cyc(1);
    chk("R5 re-enable", 32'(bus_hold_req), 1);

    chan_req = 4'b1111;
    wr(2'd1, 8'h00);              // unmask all
    bus_hold_gnt = 1'b1;
    cyc(1);
    chk("R7 highest priority first", 32'(chan_ack), 32'h1);
    chk("R8 owned during service", 32'(bus_owned), 1);

    wr(2'd1, 8'h0F);              // R6: must be ignored while granted
    chan_req = 4'b1110;
    cyc(1);
    chk("R9 ack released on request drop", 32'(chan_ack), 0);
    chk("R9 hold kept with others pending", 32'(bus_hold_req), 1);
    cyc(1);
    chk("R6/R7 next channel served, mask write ignored", 32'(chan_ack), 32'h2);

    bus_hold_gnt = 1'b0;
    cyc(1);
    chk("R12 grant withdrawn clears ack", 32'(chan_ack), 0);
    chk("R12 hold stays while eligible", 32'(bus_hold_req), 1);

    bus_hold_gnt = 1'b1;
    cyc(1);
    chk("R7 channel 1 re-acknowledged", 32'(chan_ack), 32'h2);
    chan_req = 4'b0000;
    cyc(1);
    chk("R9 hold dropped with nothing pending", 32'(bus_hold_req), 0);
    chk("R9 owned dropped", 32'(bus_owned), 0);

    chan_req = 4'b1100;
    cyc(2);
    chk("R7 channel 2 over channel 3", 32'(chan_ack), 32'h4);
    chan_req = 4'b0000;
    bus_hold_gnt = 1'b0;
    cyc(2);

    wr(2'd3, 8'hFF);              // R11: select 3 has no effect
    chan_req = 4'b0001;
    cyc(2);
    chk("R11 select 3 left masks open", 32'(bus_hold_req), 1);
    chan_req = 4'b0000;
    cyc(2);

    // constrained random traffic checked against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (chan_ack[i] && ($urandom % 4) == 0) chan_req[i] = 1'b0;
        else if (!chan_req[i] && ($urandom % 8) == 0) chan_req[i] = 1'b1;
        else if (chan_req[i] && !chan_ack[i] && ($urandom % 16) == 0) chan_req[i] = 1'b0;
      end
      if (!bus_hold_gnt && bus_hold_req && ($urandom % 3) == 0) bus_hold_gnt = 1'b1;
      else if (bus_hold_gnt && (!bus_hold_req || ($urandom % 20) == 0)) bus_hold_gnt = 1'b0;
      if (($urandom % 10) == 0) begin
        cfg_wr_en  = 1'b1;
        cfg_wr_sel = 2'($urandom % 4);
        cfg_wr_data = (cfg_wr_sel == 2'd0) ? ((($urandom % 5) == 0) ? 8'h04 : 8'h00)
                                           : 8'($urandom);
      end else begin
        cfg_wr_en = 1'b0;
      end
    end
    cfg_wr_en = 1'b0;
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule